// File: doc/BRIEF.md
# Descriptor Ring Cache Controller

This block looks after one ring of 16-byte descriptors in host memory. Software gives it the ring's base address, the ring size in bytes, a tail index and a run flag. When software moves the tail, the block reads a batch of descriptors into a small local cache and offers them one at a time to a packet engine. When the engine reports that it has finished with a descriptor, the block counts that entry as used. Used entries are written back to the ring with a DMA write. Only after that write completes does the block retire the entries and move the head index forward.

Fetch and writeback share one DMA request channel. A small state machine serialises the two, so only one request is in flight at any time. When fetch and writeback are both pending, writeback goes first. When a writeback completes, the block chains a further writeback if eligible used entries remain. Otherwise it reports that the ring is quiet enough to drain. In either case it can then ask for a refetch. The cache holds only counts and ring positions. Descriptor contents and packet data pass elsewhere.

Top module: `desc_ring_ctl`

## Requirements
- R1: The ring holds `ring_len_bytes >> 4` entries. `desc_left` shows (tail − head) modulo the ring size, one cycle after its inputs change. `desc_left` is 0 when head equals tail. After reset, `ring_head`, `desc_left`, `dma_valid` and `eng_avail` are all 0.
- R2: A `tail_wr` pulse starts a fetch only while `run` is 1. While `run` is 0, the pulse produces no DMA request.
- R3: A fetch reads at address base + 16 × fetch index. Its count is the smaller of two values. The first is the ring span, which is tail − index when tail ≥ index and otherwise ring size − index. The second is the number of free cache slots, which is DEPTH − used − unused. When that smaller value is 0, no request is made. A request never carries a count of 0.
- R4: `eng_avail` is high while the cache holds unused entries. Each `eng_done` accepted in that state turns one unused entry into a used entry. Used plus unused never exceeds DEPTH.
- R5: A full writeback (`wb_flush`) writes at base + 16 × head. Its count is the smaller of the used count and ring size − head.
- R6: A partial writeback (`wb_partial`) rounds the used count down to a multiple of BLK_BYTES/16 before applying the R5 cap. When the result is 0, no request is made.
- R7: Used entries are retired, and the head advances modulo the ring size, only in the cycle after the write completes. That cycle also carries one-cycle pulses on `head_upd` and `wb_cause`.
- R8: At write completion, a follow-up writeback is started if eligible used entries remain. Otherwise `drain_chk` pulses for one cycle.
- R9: At write completion, if `run` and `eng_idle` are both 1, a refetch is requested.
- R10: A queue-empty event occurs when the engine consumes the last unused entry while the fetch index equals the tail and no read is in flight. The event pulses `qempty_cause` and forces a full writeback and a refetch.
- R11: A request is held stable until `dma_ready`. Only one request is outstanding at a time. A pending writeback is issued before a pending fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | 1 = running, 0 = draining |
| ring_base | input | ADDR_W | Ring base byte address |
| ring_len_bytes | input | IDX_W+4 | Ring size in bytes |
| ring_tail | input | IDX_W | Tail index |
| tail_wr | input | 1 | Tail register was written |
| wb_flush | input | 1 | Request a full writeback |
| wb_partial | input | 1 | Request a block-aligned writeback |
| eng_idle | input | 1 | Packet engine is idle |
| eng_done | input | 1 | Engine finished one descriptor |
| eng_avail | output | 1 | Unused descriptor available |
| dma_valid | output | 1 | DMA request valid |
| dma_ready | input | 1 | DMA request accepted |
| dma_write | output | 1 | 1 = writeback, 0 = fetch |
| dma_addr | output | ADDR_W | Request byte address |
| dma_cnt | output | CNT_W | Descriptor count |
| dma_done | input | 1 | Outstanding request completed |
| ring_head | output | IDX_W | Head index |
| desc_left | output | IDX_W | Descriptors between head and tail |
| head_upd | output | 1 | Head advanced (pulse) |
| wb_cause | output | 1 | Descriptor-written cause (pulse) |
| qempty_cause | output | 1 | Queue-empty cause (pulse) |
| drain_chk | output | 1 | Writeback chain finished (pulse) |

## Verification
The bench aims at several boundary cases.

- **Wrapped tail.** A fetch with a wrapped tail must stop at the ring end. A design that ignored the wrap would read past the ring end.
- **Full cache.** A design that ignored free slots would overfill the cache on a tail write made while the cache is full.
- **Partial writeback.** Fewer used entries than one block must produce no write. A design that wrote them would break the alignment rule.
- **Writeback at the ring end.** This must split into two writes: one up to the end, and a follow-up from index 0 with no drain pulse between them. A design that retired entries at issue time, or wrapped the head wrongly, would show a wrong head or a missing second write.
- **Queue empty.** Consuming the last descriptor must raise the queue-empty cause. The writeback must be issued ahead of the queued refetch.
- **Randomised rings.** Random ring sizes, bases and tails check the first fetch count and the head after writeback.

// File: rtl/drc_pkg.sv
package drc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } drc_state_e;
endpackage

// File: rtl/drc_fetch_calc.sv
module drc_fetch_calc #(
  parameter int IDX_W = 8,
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] ring_len,
  input  logic [IDX_W-1:0] pnt,
  input  logic [IDX_W-1:0] tail,
  input  logic [CNT_W-1:0] used,
  input  logic [CNT_W-1:0] unused,
  output logic [CNT_W-1:0] fcnt
);
  logic [IDX_W-1:0] span;
  logic [IDX_W-1:0] free_ext;

  always_comb begin
    span     = (tail >= pnt) ? (tail - pnt) : (ring_len - pnt);
    free_ext = IDX_W'(DEPTH) - IDX_W'(used) - IDX_W'(unused);
    fcnt     = (span < free_ext) ? span[CNT_W-1:0] : free_ext[CNT_W-1:0];
  end

  // R3: a fetch never runs past the ring end
  p_fetch_in_ring_r3: assert property (@(posedge clk) disable iff (rst)
    (pnt < ring_len) |-> ({1'b0, pnt} + (IDX_W + 1)'(fcnt) <= {1'b0, ring_len}));
endmodule

// File: rtl/drc_wb_calc.sv
module drc_wb_calc #(
  parameter int IDX_W = 8,
  parameter int DEPTH = 8,
  parameter int BLK_BYTES = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] ring_len,
  input  logic [IDX_W-1:0] head,
  input  logic [CNT_W-1:0] used,
  input  logic             full,
  output logic [CNT_W-1:0] wcnt
);
  localparam int ALN_MASK = (BLK_BYTES - 1) >> 4;

  logic [CNT_W-1:0] base_cnt;
  logic [IDX_W-1:0] room;

  always_comb begin
    base_cnt = full ? used : (used & ~CNT_W'(ALN_MASK));
    room     = ring_len - head;
    wcnt     = (IDX_W'(base_cnt) < room) ? base_cnt : room[CNT_W-1:0];
  end

  // R5: a writeback never crosses the ring end
  p_wb_in_ring_r5: assert property (@(posedge clk) disable iff (rst)
    (head < ring_len) |-> ({1'b0, head} + (IDX_W + 1)'(wcnt) <= {1'b0, ring_len}));
endmodule

// File: rtl/desc_ring_ctl.sv
module desc_ring_ctl #(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 8,
  parameter int DEPTH     = 8,
  parameter int BLK_BYTES = 64,
  parameter int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [IDX_W+3:0]  ring_len_bytes,
  input  logic [IDX_W-1:0]  ring_tail,
  input  logic              tail_wr,
  input  logic              wb_flush,
  input  logic              wb_partial,
  input  logic              eng_idle,
  input  logic              eng_done,
  output logic              eng_avail,
  output logic              dma_valid,
  input  logic              dma_ready,
  output logic              dma_write,
  output logic [ADDR_W-1:0] dma_addr,
  output logic [CNT_W-1:0]  dma_cnt,
  input  logic              dma_done,
  output logic [IDX_W-1:0]  ring_head,
  output logic [IDX_W-1:0]  desc_left,
  output logic              head_upd,
  output logic              wb_cause,
  output logic              qempty_cause,
  output logic              drain_chk
);
  import drc_pkg::*;

  drc_state_e       state;
  logic [IDX_W-1:0] ring_len, pnt_q, head_q, head_nx, pnt_nx;
  logic [IDX_W:0]   hsum, psum;
  logic [CNT_W-1:0] used_q, unused_q, rcnt_q, wcnt_q, fcnt, wcnt, more_cnt;
  logic             fetch_pend, wb_pend, wb_full, infl_full;
  logic             acc_done, rd_fin, wr_fin, qempty_ev;

  assign ring_len  = ring_len_bytes[IDX_W+3:4];
  assign ring_head = head_q;
  assign eng_avail = (unused_q != '0);
  assign acc_done  = eng_done && (unused_q != '0);
  assign rd_fin    = (state == ST_RD) && dma_done && !dma_valid;
  assign wr_fin    = (state == ST_WR) && dma_done && !dma_valid;
  assign qempty_ev = acc_done && (unused_q == CNT_W'(1)) && (state != ST_RD)
                     && (pnt_q == ring_tail);

  always_comb begin
    hsum    = {1'b0, head_q} + (IDX_W + 1)'(wcnt_q);
    head_nx = (hsum >= {1'b0, ring_len}) ? IDX_W'(hsum - {1'b0, ring_len}) : hsum[IDX_W-1:0];
    psum    = {1'b0, pnt_q} + (IDX_W + 1)'(rcnt_q);
    pnt_nx  = (psum >= {1'b0, ring_len}) ? IDX_W'(psum - {1'b0, ring_len}) : psum[IDX_W-1:0];
  end

  drc_fetch_calc #(.IDX_W(IDX_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_fetch (
    .clk(clk), .rst(rst), .ring_len(ring_len), .pnt(pnt_q), .tail(ring_tail),
    .used(used_q), .unused(unused_q), .fcnt(fcnt));

  drc_wb_calc #(.IDX_W(IDX_W), .DEPTH(DEPTH), .BLK_BYTES(BLK_BYTES), .CNT_W(CNT_W)) u_wb (
    .clk(clk), .rst(rst), .ring_len(ring_len), .head(head_q),
    .used(used_q), .full(wb_full), .wcnt(wcnt));

  // Same sizing rule applied to what remains after the in-flight write
  drc_wb_calc #(.IDX_W(IDX_W), .DEPTH(DEPTH), .BLK_BYTES(BLK_BYTES), .CNT_W(CNT_W)) u_more (
    .clk(clk), .rst(rst), .ring_len(ring_len), .head(head_nx),
    .used(used_q - wcnt_q), .full(infl_full), .wcnt(more_cnt));

  // Slot counters
  always_ff @(posedge clk) begin
    if (rst) begin
      used_q   <= '0;
      unused_q <= '0;
    end else begin
      unused_q <= unused_q + (rd_fin ? rcnt_q : '0) - CNT_W'(acc_done);
      used_q   <= used_q + CNT_W'(acc_done) - (wr_fin ? wcnt_q : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) desc_left <= '0;
    else desc_left <= (ring_tail >= head_q) ? (ring_tail - head_q)
                                            : (ring_tail + ring_len - head_q);
  end

  // Request sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      dma_valid <= 1'b0; dma_write <= 1'b0; dma_addr <= '0; dma_cnt <= '0;
      rcnt_q <= '0; wcnt_q <= '0; pnt_q <= '0; head_q <= '0;
      fetch_pend <= 1'b0; wb_pend <= 1'b0; wb_full <= 1'b0; infl_full <= 1'b0;
      head_upd <= 1'b0; wb_cause <= 1'b0; qempty_cause <= 1'b0; drain_chk <= 1'b0;
    end else begin
      head_upd <= 1'b0; wb_cause <= 1'b0; qempty_cause <= 1'b0; drain_chk <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (wb_pend && wcnt != '0) begin
            dma_valid <= 1'b1; dma_write <= 1'b1; dma_cnt <= wcnt; wcnt_q <= wcnt;
            dma_addr  <= ring_base + (ADDR_W'(head_q) << 4);
            infl_full <= wb_full; wb_pend <= 1'b0; wb_full <= 1'b0;
            state     <= ST_WR;
          end else if (wb_pend) begin
            wb_pend <= 1'b0; wb_full <= 1'b0;
          end else if (fetch_pend && fcnt != '0) begin
            dma_valid <= 1'b1; dma_write <= 1'b0; dma_cnt <= fcnt; rcnt_q <= fcnt;
            dma_addr  <= ring_base + (ADDR_W'(pnt_q) << 4);
            fetch_pend <= 1'b0;
            state      <= ST_RD;
          end else if (fetch_pend) begin
            fetch_pend <= 1'b0;
          end
        end
        ST_RD: begin
          if (dma_valid && dma_ready) dma_valid <= 1'b0;
          if (rd_fin) begin
            pnt_q <= pnt_nx;
            state <= ST_IDLE;
          end
        end
        ST_WR: begin
          if (dma_valid && dma_ready) dma_valid <= 1'b0;
          if (wr_fin) begin
            head_q   <= head_nx;
            head_upd <= 1'b1;
            wb_cause <= 1'b1;
            if (more_cnt != '0) begin
              wb_pend <= 1'b1; wb_full <= infl_full;
            end else begin
              drain_chk <= 1'b1;
            end
            if (run && eng_idle) fetch_pend <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (tail_wr && run) fetch_pend <= 1'b1;
      if (wb_partial) begin
        wb_pend <= 1'b1;
        if (!wb_pend) wb_full <= 1'b0;
      end
      if (wb_flush) begin
        wb_pend <= 1'b1; wb_full <= 1'b1;
      end
      if (qempty_ev) begin
        qempty_cause <= 1'b1;
        wb_pend <= 1'b1; wb_full <= 1'b1; fetch_pend <= 1'b1;
      end
    end
  end

  // R4: cache occupancy bound
  p_cache_bound_r4: assert property (@(posedge clk) disable iff (rst)
    ((CNT_W + 1)'(used_q) + (CNT_W + 1)'(unused_q)) <= (CNT_W + 1)'(DEPTH));
  // R11: a request stays put until accepted
  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (dma_valid && !dma_ready) |=> (dma_valid && $stable(dma_addr) && $stable(dma_cnt)
                                   && $stable(dma_write)));
  // R3: no empty request
  p_req_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    dma_valid |-> (dma_cnt != '0));
  // R7: head moves only after a write completion
  p_head_on_done_r7: assert property (@(posedge clk) disable iff (rst)
    (ring_head != $past(ring_head)) |-> $past(dma_done && dma_write));
endmodule

// File: tb/desc_ring_ctl_bench.sv
module desc_ring_ctl_bench;
  localparam int ADDR_W = 32, IDX_W = 8, DEPTH = 8, CNT_W = 4;

  logic clk = 1'b0, rst = 1'b1, run = 1'b0;
  logic [ADDR_W-1:0] ring_base = '0;
  logic [IDX_W+3:0]  ring_len_bytes = '0;
  logic [IDX_W-1:0]  ring_tail = '0;
  logic tail_wr = 0, wb_flush = 0, wb_partial = 0, eng_idle = 0, eng_done = 0;
  logic dma_ready = 0, dma_done = 0;
  logic eng_avail, dma_valid, dma_write, head_upd, wb_cause, qempty_cause, drain_chk;
  logic [ADDR_W-1:0] dma_addr;
  logic [CNT_W-1:0]  dma_cnt;
  logic [IDX_W-1:0]  ring_head, desc_left;

  int n_chk = 0, n_err = 0;
  bit g_hu, g_wc, g_dc, q_seen;

  desc_ring_ctl u_desc_ring_ctl (
    .clk(clk), .rst(rst), .run(run), .ring_base(ring_base), .ring_len_bytes(ring_len_bytes),
    .ring_tail(ring_tail), .tail_wr(tail_wr), .wb_flush(wb_flush), .wb_partial(wb_partial),
    .eng_idle(eng_idle), .eng_done(eng_done), .eng_avail(eng_avail), .dma_valid(dma_valid),
    .dma_ready(dma_ready), .dma_write(dma_write), .dma_addr(dma_addr), .dma_cnt(dma_cnt),
    .dma_done(dma_done), .ring_head(ring_head), .desc_left(desc_left), .head_upd(head_upd),
    .wb_cause(wb_cause), .qempty_cause(qempty_cause), .drain_chk(drain_chk));

  always #5 clk = ~clk;

  task automatic chk(input string r, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_tail();
    tail_wr = 1'b1; @(negedge clk); tail_wr = 1'b0;
  endtask

  // Wait for a request, check it, accept after 'hold' cycles, then complete it
  task automatic expect_req(input string r, input bit wr, input longint addr,
                            input longint cnt, input int hold);
    int w = 0;
    while (!dma_valid && w < 40) begin @(negedge clk); w++; end
    chk({r, " valid"}, dma_valid, 1);
    chk({r, " write"}, dma_write, wr);
    chk({r, " addr"}, dma_addr, addr);
    chk({r, " cnt"}, dma_cnt, cnt);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk({r, " R11 hold"}, {dma_valid, dma_addr}, {1'b1, addr[ADDR_W-1:0]});
    end
    dma_ready = 1'b1; @(negedge clk); dma_ready = 1'b0;
    dma_done = 1'b1; @(negedge clk);
    g_hu = head_upd; g_wc = wb_cause; g_dc = drain_chk;
    dma_done = 1'b0;
  endtask

  task automatic no_req(input string r, input int n);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (dma_valid) seen = 1; end
    chk(r, seen, 0);
  endtask

  task automatic eng(input int n);
    q_seen = 0;
    for (int i = 0; i < n; i++) begin
      eng_done = 1'b1; @(negedge clk);
      if (qempty_cause) q_seen = 1;
    end
    eng_done = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    chk("R1 reset head", ring_head, 0);
    chk("R1 reset left", desc_left, 0);
    chk("R1 reset valid", dma_valid, 0);
    chk("R1 reset avail", eng_avail, 0);

    // Draining: tail write ignored
    ring_base = 32'h1000; ring_len_bytes = 12'd512; ring_tail = 8'd5;
    pulse_tail();
    no_req("R2 no fetch while draining", 6);
    chk("R1 desc_left", desc_left, 5);

    // Running: fetch 5 from index 0
    run = 1'b1; pulse_tail();
    expect_req("R3 first fetch", 0, 32'h1000, 5, 0);
    chk("R4 avail", eng_avail, 1);
    eng(5);
    chk("R10 qempty", q_seen, 1);
    expect_req("R11 wb before fetch / R5", 1, 32'h1000, 5, 3);
    chk("R7 head_upd", g_hu, 1);
    chk("R7 wb_cause", g_wc, 1);
    chk("R8 drain", g_dc, 1);
    chk("R7 head", ring_head, 5);
    @(negedge clk);
    chk("R1 empty", desc_left, 0);
    chk("R4 avail empty", eng_avail, 0);

    // Wrapped tail, capped by cache size
    ring_tail = 8'd2; pulse_tail();
    expect_req("R3 wrap cap", 0, 32'h1050, 8, 0);
    @(negedge clk);
    chk("R1 wrapped left", desc_left, 29);
    pulse_tail();
    no_req("R3 full cache no fetch", 6);
    eng(3);
    wb_partial = 1'b1; @(negedge clk); wb_partial = 1'b0;
    no_req("R6 below block no write", 6);
    eng(2);
    eng_idle = 1'b1;
    wb_partial = 1'b1; @(negedge clk); wb_partial = 1'b0;
    expect_req("R6 partial wb", 1, 32'h1050, 4, 0);
    chk("R7 head partial", ring_head, 9);
    chk("R8 drain partial", g_dc, 1);
    expect_req("R9 refetch", 0, 32'h10D0, 4, 0);
    eng_idle = 1'b0;

    // Small ring: writeback split at the ring end
    do_reset();
    ring_base = 32'h2000; ring_len_bytes = 12'd128; ring_tail = 8'd6;
    pulse_tail();
    expect_req("R3 small fetch", 0, 32'h2000, 6, 0);
    eng(6);
    chk("R10 qempty small", q_seen, 1);
    expect_req("R5 small wb", 1, 32'h2000, 6, 0);
    ring_tail = 8'd3; pulse_tail();
    expect_req("R3 fetch to ring end", 0, 32'h2060, 2, 0);
    pulse_tail();
    expect_req("R3 fetch after wrap", 0, 32'h2000, 3, 0);
    eng(5);
    chk("R10 qempty wrap", q_seen, 1);
    expect_req("R5 wb to ring end", 1, 32'h2060, 2, 0);
    chk("R7 head wraps", ring_head, 0);
    chk("R8 no drain mid chain", g_dc, 0);
    expect_req("R8 follow-up wb", 1, 32'h2000, 3, 0);
    chk("R7 head after chain", ring_head, 3);
    chk("R8 drain end chain", g_dc, 1);

    // Randomised rings
    for (int it = 0; it < 20; it++) begin
      int len, tl, ex, k;
      longint bs;
      do_reset();
      len = 4 + int'($urandom % 60);
      tl  = 1 + int'($urandom % (len - 1));
      bs  = longint'($urandom % 4096) << 4;
      ring_base = bs[31:0]; ring_len_bytes = 12'(len * 16); ring_tail = 8'(tl);
      ex = (tl < DEPTH) ? tl : DEPTH;
      k  = 1 + int'($urandom % ex);
      pulse_tail();
      expect_req("R3 rand fetch", 0, bs, ex, 0);
      eng(k);
      wb_flush = 1'b1; @(negedge clk); wb_flush = 1'b0;
      expect_req("R5 rand wb", 1, bs, k, 0);
      chk("R7 rand head", ring_head, k);
      @(negedge clk);
      chk("R1 rand left", desc_left, tl - k);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule